// File: doc/BRIEF.md
# Four-Phase Vernier Hit-Time Combiner

This block takes one hit from four time-to-digital sub-units that sample the same input edge on four clocks. The clocks share a 4 ns period and are spaced about 1 ns apart. For every sub-unit the block receives a coarse cycle count and a 64-tap delay-line thermometer code. The block checks each code and turns clean codes into a tap index. It builds a corrected time for each usable sub-unit and averages those times into one hit timestamp, expressed in picosecond-scale fixed-point units. A hit usually has three usable sub-units and never fewer than two, so a result built from fewer than two is flagged as bad.

Hits arrive and leave on valid/ready streams. An input beat transfers on a clock edge where `s_valid` and `s_ready` are both high. An output beat transfers on an edge where `m_valid` and `m_ready` are both high. The pipeline runs under one global advance condition. While a result sits on the output and `m_ready` is low, every stage freezes and `s_ready` drops, so back-pressure reaches the source within the same cycle. With `m_ready` held high, the block accepts one hit per cycle.

Top module: `tdc_phase_merge`

## Requirements
- R1: `s_ready` is low exactly when `m_valid` is high and `m_ready` is low; otherwise it is high and an asserted `s_valid` is accepted on that edge.
- R2: With no back-pressure, a hit accepted on clock edge k is presented on `m_valid` after edge k+3, with four registers on the path.
- R3: Lane i uses `s_therm[64*i +: 64]`, and bit 0 is the first delay tap. A clean code has k low bits set (1 ≤ k ≤ 64) and every other bit clear. It gives tap index k−1, so the range is 0 to 63.
- R4: A lane whose code is all zeros, or has a set bit above a clear bit, is left out of the average and out of `m_nvalid`.
- R5: Lane i's corrected time is coarse × PERIOD_U + i × PHASE_U + (63 − index) × TAP_U, using the lane's coarse count `s_coarse[16*i +: 16]` and the defaults PERIOD_U = 4000, PHASE_U = 1000 and TAP_U = 62.
- R6: With n usable lanes (n = 2, 3 or 4), `m_time` is the sum of their corrected times divided by n and rounded down. This holds exactly even at the largest coarse count.
- R7: `m_nvalid` gives the number of usable lanes. When it is below 2, `m_ok` is 0 and `m_time` is 0; otherwise `m_ok` is 1.
- R8: While `m_valid` is high and `m_ready` is low, the outputs hold steady. No accepted hit is lost or reordered.
- R9: After reset, `m_valid` is low and `s_ready` is high.
- R10: Hits offered back to back with `m_ready` high leave on consecutive cycles, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for every stage |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input hit offered |
| s_ready | output | 1 | Block can take a hit this cycle |
| s_coarse | input | 4*COARSE_W | Coarse counts, lane i at bits [COARSE_W*i +: COARSE_W] |
| s_therm | input | 256 | Thermometer codes, lane i at bits [64*i +: 64] |
| m_valid | output | 1 | Result available |
| m_ready | input | 1 | Consumer takes the result |
| m_time | output | COARSE_W+13 | Averaged hit time in fixed-point units |
| m_ok | output | 1 | At least two usable lanes contributed |
| m_nvalid | output | 3 | Count of usable lanes, 0 to 4 |

## Verification
The assertions check the stream rules on every cycle. These are the coupling of `s_ready` to output back-pressure, the output holding steady while stalled, and the bad-result encoding: zero time with fewer than two lanes, and two or more lanes whenever `m_ok` is high. Only the bench scenarios can show the arithmetic. That covers how codes are classified, the tap index at both ends of the delay line, the per-lane phase and tap correction, and exact division by three at a large coarse count. They also cover the latency count, back-to-back ordering, and the release order of hits that were held during a stall.

// File: rtl/tdcm_pkg.sv
package tdcm_pkg;
  localparam int LANES = 4;
  localparam int TAPS  = 64;
  localparam int GRP   = 8;
  localparam int NGRP  = TAPS / GRP;
  localparam int GCW   = $clog2(GRP + 1);
  localparam int CNTW  = $clog2(TAPS + 1);
  localparam int IDXW  = $clog2(TAPS);
  localparam int NCW   = $clog2(LANES + 1);
endpackage

// File: rtl/tdcm_therm_scan.sv
// First conversion stage for one lane: per-group ones counts and a bubble flag.
module tdcm_therm_scan
  import tdcm_pkg::*;
(
  input  logic [TAPS-1:0]            therm,
  output logic [NGRP-1:0][GCW-1:0]   grp_cnt,
  output logic                       bubble
);
  always_comb begin
    bubble = 1'b0;
    for (int b = 0; b < TAPS - 1; b++) begin
      // a one above a zero breaks the run-of-ones shape
      bubble = bubble | (therm[b+1] & ~therm[b]);
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_comb begin
      grp_cnt[g] = '0;
      for (int b = 0; b < GRP; b++) begin
        grp_cnt[g] = grp_cnt[g] + GCW'(therm[g*GRP + b]);
      end
    end
  end
endmodule

// File: rtl/tdcm_lane_time.sv
// Second stage for one lane: tap index, lane usability and corrected time.
module tdcm_lane_time
  import tdcm_pkg::*;
#(
  parameter int COARSE_W = 16,
  parameter int PERIOD_U = 4000,
  parameter int PHASE_U  = 1000,
  parameter int TAP_U    = 62,
  parameter int LANE     = 0,
  parameter int TW       = 29
) (
  input  logic [COARSE_W-1:0]        coarse,
  input  logic [NGRP-1:0][GCW-1:0]   grp_cnt,
  input  logic                       bubble,
  output logic [TW-1:0]              t_corr,
  output logic                       usable
);
  logic [CNTW-1:0] ones;
  logic [CNTW-1:0] idx_w;
  logic [IDXW-1:0] idx;
  logic [TW-1:0]   t_coarse;
  logic [TW-1:0]   t_tap;

  always_comb begin
    ones = '0;
    for (int g = 0; g < NGRP; g++) begin
      ones = ones + CNTW'(grp_cnt[g]);
    end
  end

  assign usable   = ~bubble & (ones != '0);
  assign idx_w    = ones - CNTW'(1);
  assign idx      = idx_w[IDXW-1:0];
  assign t_coarse = TW'(coarse) * TW'(PERIOD_U);
  assign t_tap    = TW'(TAPS - 1 - int'(idx)) * TW'(TAP_U);

  always_comb begin
    if (usable) t_corr = t_coarse + TW'(LANE * PHASE_U) + t_tap;
    else        t_corr = '0;
  end
endmodule

// File: rtl/tdcm_avg_div.sv
// Divides a lane sum by the usable count 2, 3 or 4; the divide by three
// uses a reciprocal multiply that is exact for every sum below 2**SW.
module tdcm_avg_div
  import tdcm_pkg::*;
#(
  parameter int TW = 29,
  parameter int SW = 31
) (
  input  logic [SW-1:0]  sum,
  input  logic [NCW-1:0] n,
  output logic [TW-1:0]  quot,
  output logic           ok
);
  localparam int PW = 2 * SW + 2;
  localparam logic [SW+1:0] POW   = {1'b1, {(SW+1){1'b0}}};
  localparam logic [SW+1:0] RFULL = POW / 3 + 1;
  localparam logic [SW:0]   RECIP = RFULL[SW:0];

  logic [PW-1:0] prod;
  logic [SW-1:0] half;
  logic [SW-1:0] quarter;

  assign prod    = PW'(sum) * PW'(RECIP);
  assign half    = sum >> 1;
  assign quarter = sum >> 2;
  assign ok      = (n >= NCW'(2));

  always_comb begin
    case (n)
      NCW'(2): quot = half[TW-1:0];
      NCW'(3): quot = prod[SW+1 +: TW];
      NCW'(4): quot = quarter[TW-1:0];
      default: quot = '0;
    endcase
  end
endmodule

// File: rtl/tdc_phase_merge.sv
module tdc_phase_merge
  import tdcm_pkg::*;
#(
  parameter int COARSE_W = 16,
  parameter int PERIOD_U = 4000,
  parameter int PHASE_U  = 1000,
  parameter int TAP_U    = 62
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         s_valid,
  output logic                         s_ready,
  input  logic [LANES*COARSE_W-1:0]    s_coarse,
  input  logic [LANES*TAPS-1:0]        s_therm,
  output logic                         m_valid,
  input  logic                         m_ready,
  output logic [COARSE_W+12:0]         m_time,
  output logic                         m_ok,
  output logic [NCW-1:0]               m_nvalid
);
  localparam int TW = COARSE_W + $clog2(PERIOD_U) + 1;
  localparam int SW = TW + $clog2(LANES);

  logic adv;
  assign adv     = ~m_valid | m_ready;
  assign s_ready = adv;

  // stage 1: group counts and bubble flags
  logic                                   v1;
  logic [LANES-1:0][COARSE_W-1:0]         coarse1;
  logic [LANES-1:0][NGRP-1:0][GCW-1:0]    gcnt_c, gcnt1;
  logic [LANES-1:0]                       bub_c, bub1;

  // stage 2: corrected per-lane times
  logic                                   v2;
  logic [LANES-1:0][TW-1:0]               tc_c, tc2;
  logic [LANES-1:0]                       use_c, use2;

  // stage 3: sum and count
  logic                                   v3;
  logic [SW-1:0]                          sum_c, sum3;
  logic [NCW-1:0]                         n_c, n3;

  // stage 4 (output) inputs
  logic [TW-1:0]                          quot_c;
  logic                                   ok_c;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tdcm_therm_scan u_scan (
      .therm   (s_therm[i*TAPS +: TAPS]),
      .grp_cnt (gcnt_c[i]),
      .bubble  (bub_c[i])
    );

    tdcm_lane_time #(
      .COARSE_W (COARSE_W),
      .PERIOD_U (PERIOD_U),
      .PHASE_U  (PHASE_U),
      .TAP_U    (TAP_U),
      .LANE     (i),
      .TW       (TW)
    ) u_time (
      .coarse  (coarse1[i]),
      .grp_cnt (gcnt1[i]),
      .bubble  (bub1[i]),
      .t_corr  (tc_c[i]),
      .usable  (use_c[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        coarse1[i] <= '0;
        gcnt1[i]   <= '0;
        bub1[i]    <= 1'b0;
        tc2[i]     <= '0;
        use2[i]    <= 1'b0;
      end else if (adv) begin
        coarse1[i] <= s_coarse[i*COARSE_W +: COARSE_W];
        gcnt1[i]   <= gcnt_c[i];
        bub1[i]    <= bub_c[i];
        tc2[i]     <= tc_c[i];
        use2[i]    <= use_c[i];
      end
    end
  end

  always_comb begin
    sum_c = '0;
    n_c   = '0;
    for (int i = 0; i < LANES; i++) begin
      if (use2[i]) begin
        sum_c = sum_c + SW'(tc2[i]);
        n_c   = n_c + NCW'(1);
      end
    end
  end

  tdcm_avg_div #(
    .TW (TW),
    .SW (SW)
  ) u_div (
    .sum  (sum3),
    .n    (n3),
    .quot (quot_c),
    .ok   (ok_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1       <= 1'b0;
      v2       <= 1'b0;
      v3       <= 1'b0;
      sum3     <= '0;
      n3       <= '0;
      m_valid  <= 1'b0;
      m_time   <= '0;
      m_ok     <= 1'b0;
      m_nvalid <= '0;
    end else if (adv) begin
      v1       <= s_valid;
      v2       <= v1;
      v3       <= v2;
      sum3     <= sum_c;
      n3       <= n_c;
      m_valid  <= v3;
      m_time   <= ok_c ? quot_c : '0;
      m_ok     <= ok_c;
      m_nvalid <= n3;
    end
  end
endmodule

// File: rtl/tdcm_checker.sv
module tdcm_checker #(
  parameter int COARSE_W = 16,
  parameter int PERIOD_U = 4000
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        s_valid,
  input logic                        s_ready,
  input logic                        m_valid,
  input logic                        m_ready,
  input logic [COARSE_W+12:0]        m_time,
  input logic                        m_ok,
  input logic [2:0]                  m_nvalid
);
  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  a_r1_free_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_valid || m_ready) |-> s_ready);

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_time) && $stable(m_ok) && $stable(m_nvalid)));

  a_r7_ok_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ok) |-> (m_nvalid >= 3'd2 && m_nvalid <= 3'd4));

  a_r7_bad_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ok) |-> (m_time == '0 && m_nvalid < 3'd2));
endmodule

bind tdc_phase_merge tdcm_checker #(
  .COARSE_W (COARSE_W),
  .PERIOD_U (PERIOD_U)
) u_tdcm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_time   (m_time),
  .m_ok     (m_ok),
  .m_nvalid (m_nvalid)
);

// File: tb/tdc_phase_merge_bench.sv
module tdc_phase_merge_bench;
  localparam int CW = 16;
  localparam int TWB = 29;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            s_valid = 1'b0;
  logic            s_ready;
  logic [4*CW-1:0] s_coarse = '0;
  logic [255:0]    s_therm = '0;
  logic            m_valid;
  logic            m_ready = 1'b1;
  logic [TWB-1:0]  m_time;
  logic            m_ok;
  logic [2:0]      m_nvalid;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [CW-1:0] vco [4];
  logic [63:0]   vth [4];

  always #5 clk = ~clk;

  tdc_phase_merge u_tdc_phase_merge (
    .clk (clk), .rst_n (rst_n),
    .s_valid (s_valid), .s_ready (s_ready),
    .s_coarse (s_coarse), .s_therm (s_therm),
    .m_valid (m_valid), .m_ready (m_ready),
    .m_time (m_time), .m_ok (m_ok), .m_nvalid (m_nvalid)
  );

  function automatic logic [63:0] tm(int k);
    if (k == 0) return 64'h0;
    return {64{1'b1}} >> (64 - k);
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected result computed from the requirement text
  task automatic calc(output longint t, output bit ok, output int n);
    longint sum = 0;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      int k = 0;
      while (k < 64 && vth[i][k]) k++;
      if (k > 0 && (k == 64 || (vth[i] >> k) == 64'h0)) begin
        sum += longint'(vco[i]) * 4000 + i * 1000 + (63 - (k - 1)) * 62;
        n++;
      end
    end
    ok = (n >= 2);
    t = ok ? sum / n : 0;
  endtask

  task automatic drive();
    for (int i = 0; i < 4; i++) begin
      s_coarse[i*CW +: CW] = vco[i];
      s_therm[i*64 +: 64]  = vth[i];
    end
    s_valid = 1'b1;
  endtask

  task automatic check_out(string req, longint t, bit ok, int n);
    check({req, " valid"}, longint'(m_valid), 1);
    check({req, " time"}, longint'(m_time), t);
    check({req, " ok"}, longint'(m_ok), longint'(ok));
    check({req, " count"}, longint'(m_nvalid), n);
  endtask

  // one hit, no back-pressure: latency and value
  task automatic one_hit(string req);
    longint t; bit ok; int n;
    calc(t, ok, n);
    drive();
    @(negedge clk);
    s_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({req, " R2 not early"}, longint'(m_valid), 0);
    @(negedge clk);
    check_out(req, t, ok, n);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R9 m_valid", longint'(m_valid), 0);
    check("R9 s_ready", longint'(s_ready), 1);
  endtask

  task automatic t_all_four();
    vco = '{16'd100, 16'd100, 16'd100, 16'd101};
    vth = '{tm(10), tm(20), tm(30), tm(40)};
    one_hit("R5 R6 four lanes");
  endtask

  task automatic t_bubble_three();
    vco = '{16'd5000, 16'd5000, 16'd4999, 16'd5000};
    vth = '{tm(7), tm(20) | (64'h1 << 40), tm(33), tm(2)};
    one_hit("R4 R6 bubble lane, three used");
  endtask

  task automatic t_two();
    vco = '{16'd9, 16'd12, 16'd12, 16'd13};
    vth = '{64'h0, tm(5), 64'h8000_0000_0000_0001, tm(50)};
    one_hit("R4 R6 two used");
  endtask

  task automatic t_one();
    vco = '{16'd3, 16'd3, 16'd3, 16'd3};
    vth = '{tm(12), 64'h0, 64'h0, 64'h0000_00F0_0000_0000};
    one_hit("R7 single lane");
  endtask

  task automatic t_tap_ends();
    vco = '{16'd20, 16'd20, 16'd0, 16'd0};
    vth = '{tm(1), tm(64), 64'h0, 64'h0};
    one_hit("R3 index 0 and 63");
  endtask

  task automatic t_big_div3();
    vco = '{16'hFFFF, 16'hFFFF, 16'hFFFE, 16'hFFFF};
    vth = '{tm(1), tm(40), tm(64), 64'h2};
    one_hit("R6 div3 at max coarse");
  endtask

  task automatic t_back_to_back();
    longint et[3]; bit eo[3]; int en[3];
    m_ready = 1'b1;
    for (int j = 0; j < 3; j++) begin
      vco = '{16'(10 + j), 16'(10 + j), 16'(11 + j), 16'(11 + j)};
      vth = '{tm(3 + j), tm(9), tm(15 + 2 * j), (j == 1) ? 64'h0 : tm(60)};
      calc(et[j], eo[j], en[j]);
      drive();
      @(negedge clk);
    end
    s_valid = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check_out("R10 back to back", et[j], eo[j], en[j]);
    end
    @(negedge clk);
  endtask

  task automatic t_backpressure();
    longint et[3]; bit eo[3]; int en[3];
    m_ready = 1'b0;
    for (int j = 0; j < 3; j++) begin
      vco = '{16'(700 * j + 1), 16'(700 * j + 1), 16'(700 * j + 1), 16'(700 * j + 2)};
      vth = '{tm(8 * j + 4), tm(25), tm(11), tm(j + 1)};
      calc(et[j], eo[j], en[j]);
      drive();
      @(negedge clk);
    end
    s_valid = 1'b0;
    @(negedge clk);
    check_out("R8 first held", et[0], eo[0], en[0]);
    check("R1 s_ready low when stalled", longint'(s_ready), 0);
    for (int c = 0; c < 3; c++) @(negedge clk);
    check_out("R8 still held", et[0], eo[0], en[0]);
    m_ready = 1'b1;
    @(negedge clk);
    check_out("R8 second released", et[1], eo[1], en[1]);
    check("R1 s_ready back", longint'(s_ready), 1);
    @(negedge clk);
    check_out("R8 third released", et[2], eo[2], en[2]);
    @(negedge clk);
    check("R8 drained", longint'(m_valid), 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_all_four();
    t_bubble_three();
    t_two();
    t_one();
    t_tap_ends();
    t_big_div3();
    t_back_to_back();
    t_backpressure();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule